// File: doc/BRIEF.md
# Set Reference History Table

This block keeps a short, fully associative list of the cache set indices that were referenced most recently. A cache controller uses it to decide which sets are likely to be touched again soon: a set that is listed should keep its line in place, and a miss to it should find a victim somewhere else. Each time a set index is newly recorded, the block sends a one-cycle pulse carrying that index so that the cache can clear the per-set "safe to discard" flag for it.

Every cache access reports its set index on the access port, whether it hit or missed. An access that was served by the out-of-position mapping table is flagged and leaves the history untouched. When the table is full, recording a new index pushes out the least recently referenced one. A set that becomes the home of an out-of-position mapping must not stay listed, so a removal port deletes a given index. A separate lookup port reports in the same cycle whether an index is listed.

Top module: `set_history_table`

## Requirements
- R1: After a reset with `rst_n` low, no index is listed (every lookup reports a miss) and `clr_valid` is low.
- R2: `lk_hit` answers combinationally from the current contents, in the same cycle that `lk_set` is presented, with no clock edge in between.
- R3: An access with `acc_valid` high and `acc_oph` low records `acc_set`; from the next cycle on a lookup of that index hits (unless R9 applies).
- R4: An access with `acc_oph` high changes neither the contents nor the recency order and raises no pulse.
- R5: Recording an index that was not listed raises `clr_valid` for exactly the cycle after the access, with `clr_set` equal to that index; an access to an index already listed raises no pulse.
- R6: An index is never listed twice; an access to a listed index only makes it the most recent one.
- R7: When all ENTRIES slots hold indices, recording a new index drops the least recently referenced one, which then misses on lookup.
- R8: With `rm_valid` high, the index on `rm_set` is deleted from the next cycle on; removing an index that is not listed changes nothing.
- R9: When a removal and a recorded access name the same index in one cycle, the removal wins: the index is not listed afterwards and no pulse is raised.
- R10: When a removal and a recorded access name different indices in one cycle, both take effect, and the slot freed by the removal is used so that no other index is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_valid | input | 1 | A cache access happens this cycle |
| acc_set | input | SET_W | Set index of the access |
| acc_oph | input | 1 | The access hit in the out-of-position table |
| rm_valid | input | 1 | Delete an index from the table this cycle |
| rm_set | input | SET_W | Index to delete |
| lk_set | input | SET_W | Index to look up |
| lk_hit | output | 1 | `lk_set` is listed (combinational) |
| clr_valid | output | 1 | Pulse: clear the discard flag of `clr_set` |
| clr_set | output | SET_W | Set index whose discard flag is cleared |

## Verification
The lookup result is due in the same cycle as its index, so the bench drives `lk_set` just after a falling edge and compares `lk_hit` one nanosecond later, before the next rising edge changes the contents. The clear pulse comes from a register and is due one rising edge after the access that caused it; the bench samples `clr_valid` and `clr_set` one nanosecond after that edge and expects them low in every other cycle. Changes to the contents from an access or a removal show up on the lookup port in the cycle after the edge, and the behavioural queue model in the bench is advanced at the same edge so that both sides compare the same state.

// File: rtl/sht_pkg.sv
`timescale 1ns/1ps
// Shared declarations for the set reference history table.
// Assumes nothing beyond IEEE 1800-2017 packages.
package sht_pkg;

    // What the table does with the access presented in a cycle.
    typedef enum logic [1:0] {
        OP_IDLE   = 2'd0,   // no recorded access (none, out-of-position hit, or cancelled)
        OP_TOUCH  = 2'd1,   // index already listed: refresh recency only
        OP_INSERT = 2'd2    // index not listed: take a slot, raise the clear pulse
    } sht_op_e;

    localparam int unsigned DEF_ENTRIES = 8;
    localparam int unsigned DEF_SET_W   = 6;

endpackage

// File: rtl/sht_cam_match.sv
`timescale 1ns/1ps
// Parallel comparator of one key against every slot of the table.
// Produces one bit per slot: slot valid and its tag equals the key.
// Assumes the caller guarantees at most one valid slot per tag.
module sht_cam_match #(
    parameter int unsigned ENTRIES = 8,
    parameter int unsigned SET_W   = 6
) (
    input  logic [ENTRIES-1:0]            vld,
    input  logic [ENTRIES-1:0][SET_W-1:0] tags,
    input  logic [SET_W-1:0]              key,
    output logic [ENTRIES-1:0]            hit
);

    // One comparator per slot.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit[g] = vld[g] && (tags[g] == key);
    end

endmodule

// File: rtl/sht_slot_pick.sv
`timescale 1ns/1ps
// Chooses where a new index goes: the lowest free slot if any, and
// separately the slot holding the least recent index (rank ENTRIES-1).
// Assumes valid slots carry distinct ranks 0..n-1, 0 being most recent.
module sht_slot_pick #(
    parameter int unsigned ENTRIES = 8,
    parameter int unsigned IDX_W   = 3
) (
    input  logic [ENTRIES-1:0]            vld,
    input  logic [ENTRIES-1:0][IDX_W-1:0] rank,
    output logic                          free_any,
    output logic [IDX_W-1:0]              free_idx,
    output logic [IDX_W-1:0]              lru_idx
);

    localparam logic [IDX_W-1:0] OLDEST = IDX_W'(ENTRIES - 1);

    // Lowest-numbered invalid slot, scanned from the top so index 0 wins.
    always_comb begin
        free_any = 1'b0;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!vld[i]) begin
                free_any = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    // Slot whose rank marks it least recently referenced (meaningful when full).
    always_comb begin
        lru_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (vld[i] && rank[i] == OLDEST) begin
                lru_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/set_history_table.sv
`timescale 1ns/1ps
// Set reference history table.
// Keeps up to ENTRIES recently referenced set indices, fully associative,
// with LRU replacement by per-slot recency ranks. Each cycle a removal is
// applied first, then the access (if recorded) on the post-removal state.
// A newly recorded index raises clr_valid/clr_set one cycle later.
// lk_hit is combinational on the registered contents.
// Assumes ENTRIES >= 2; reset is synchronous and active low.
module set_history_table
    import sht_pkg::*;
#(
    parameter int unsigned ENTRIES = DEF_ENTRIES,
    parameter int unsigned SET_W   = DEF_SET_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic [SET_W-1:0] acc_set,
    input  logic             acc_oph,
    input  logic             rm_valid,
    input  logic [SET_W-1:0] rm_set,
    input  logic [SET_W-1:0] lk_set,
    output logic             lk_hit,
    output logic             clr_valid,
    output logic [SET_W-1:0] clr_set
);

    localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0]            vld_q,  vld_mid,  vld_d;
    logic [ENTRIES-1:0][SET_W-1:0] tag_q,  tag_d;
    logic [ENTRIES-1:0][IDX_W-1:0] rank_q, rank_mid, rank_d;

    logic [ENTRIES-1:0] acc_hit, rm_hit, lk_match, touch_hit;
    logic               free_any;
    logic [IDX_W-1:0]   free_idx, lru_idx, slot;
    logic               acc_go, clr_d;
    sht_op_e            op_kind;

    sht_cam_match #(.ENTRIES(ENTRIES), .SET_W(SET_W)) u_acc_cmp (
        .vld(vld_q), .tags(tag_q), .key(acc_set), .hit(acc_hit));
    sht_cam_match #(.ENTRIES(ENTRIES), .SET_W(SET_W)) u_rm_cmp (
        .vld(vld_q), .tags(tag_q), .key(rm_set), .hit(rm_hit));
    sht_cam_match #(.ENTRIES(ENTRIES), .SET_W(SET_W)) u_lk_cmp (
        .vld(vld_q), .tags(tag_q), .key(lk_set), .hit(lk_match));

    sht_slot_pick #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_pick (
        .vld(vld_mid), .rank(rank_mid),
        .free_any(free_any), .free_idx(free_idx), .lru_idx(lru_idx));

    // Membership answer for the lookup port, same cycle.
    assign lk_hit = |lk_match;

    // Removal step: drop the matching slot and close the gap in the ranks.
    always_comb begin
        logic [IDX_W-1:0] gone_rank;
        gone_rank = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (rm_hit[i]) gone_rank = gone_rank | rank_q[i];
        end
        vld_mid  = vld_q;
        rank_mid = rank_q;
        if (rm_valid && (|rm_hit)) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (rm_hit[i]) vld_mid[i] = 1'b0;
                else if (vld_q[i] && rank_q[i] > gone_rank)
                    rank_mid[i] = rank_q[i] - IDX_W'(1);
            end
        end
    end

    // Classify the access against the post-removal contents.
    always_comb begin
        acc_go    = acc_valid && !acc_oph && !(rm_valid && rm_set == acc_set);
        touch_hit = acc_hit & vld_mid;
        slot      = free_any ? free_idx : lru_idx;
        if (!acc_go)          op_kind = OP_IDLE;
        else if (|touch_hit)  op_kind = OP_TOUCH;
        else                  op_kind = OP_INSERT;
    end

    // Access step: refresh or insert at rank 0, age the younger entries.
    always_comb begin
        logic [IDX_W-1:0] ref_rank;
        ref_rank = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (touch_hit[i]) ref_rank = ref_rank | rank_mid[i];
        end
        vld_d  = vld_mid;
        rank_d = rank_mid;
        tag_d  = tag_q;
        clr_d  = 1'b0;
        case (op_kind)
            OP_TOUCH: begin
                for (int i = 0; i < ENTRIES; i++) begin
                    if (touch_hit[i])
                        rank_d[i] = '0;
                    else if (vld_mid[i] && rank_mid[i] < ref_rank)
                        rank_d[i] = rank_mid[i] + IDX_W'(1);
                end
            end
            OP_INSERT: begin
                for (int i = 0; i < ENTRIES; i++) begin
                    if (IDX_W'(i) == slot) begin
                        vld_d[i]  = 1'b1;
                        tag_d[i]  = acc_set;
                        rank_d[i] = '0;
                    end else if (vld_mid[i]) begin
                        rank_d[i] = rank_mid[i] + IDX_W'(1);
                    end
                end
                clr_d = 1'b1;
            end
            default: ;
        endcase
    end

    // Table state registers; reset empties every slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= '0;
            tag_q  <= '0;
            rank_q <= '0;
        end else begin
            vld_q  <= vld_d;
            tag_q  <= tag_d;
            rank_q <= rank_d;
        end
    end

    // Registered clear pulse toward the cache's discard flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clr_valid <= 1'b0;
            clr_set   <= '0;
        end else begin
            clr_valid <= clr_d;
            clr_set   <= clr_d ? acc_set : clr_set;
        end
    end

    // Presence of an index in the registered contents (checks only).
    function automatic logic listed(input logic [SET_W-1:0] k);
        logic r;
        r = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (vld_q[i] && tag_q[i] == k) r = 1'b1;
        end
        return r;
    endfunction

    // R6: the access comparator never sees two copies of one index.
    a_r6_single_copy: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(acc_hit));

    // R5: an insertion is followed by the pulse carrying that index.
    a_r5_pulse_follows_insert: assert property (@(posedge clk) disable iff (!rst_n)
        (op_kind == OP_INSERT) |=> (clr_valid && clr_set == $past(acc_set)));

    // R5: a refresh of a listed index raises no pulse.
    a_r5_no_pulse_on_touch: assert property (@(posedge clk) disable iff (!rst_n)
        (op_kind == OP_TOUCH) |=> !clr_valid);

    // R4: an out-of-position hit with no removal leaves the state alone.
    a_r4_oph_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_oph && !rm_valid) |=> ($stable(vld_q) && $stable(rank_q) && !clr_valid));

    // R3: a recorded access leaves its index listed.
    a_r3_recorded: assert property (@(posedge clk) disable iff (!rst_n)
        acc_go |=> listed($past(acc_set)));

    // R8/R9: a removed index is absent in the next cycle.
    a_r8_removed_gone: assert property (@(posedge clk) disable iff (!rst_n)
        rm_valid |=> !listed($past(rm_set)));

    // R7: a full table keeps exactly one slot at the oldest rank.
    a_r7_one_oldest: assert property (@(posedge clk) disable iff (!rst_n)
        (&vld_q) |-> ($countones(vld_q & ~(vld_q ^ vld_q)) == ENTRIES && lru_idx_ok()));

    function automatic logic lru_idx_ok();
        int n;
        n = 0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (rank_q[i] == IDX_W'(ENTRIES - 1)) n++;
        end
        return (n == 1);
    endfunction

endmodule

// File: tb/sim_set_history_table.sv
`timescale 1ns/1ps
// Bench for set_history_table: a queue model (front = most recent) is
// advanced at each rising edge and compared with the ports every cycle.
module sim_set_history_table;

    localparam int ENTRIES = 8;
    localparam int SET_W   = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             acc_valid = 1'b0, acc_oph = 1'b0, rm_valid = 1'b0;
    logic [SET_W-1:0] acc_set = '0, rm_set = '0, lk_set = '0;
    logic             lk_hit, clr_valid;
    logic [SET_W-1:0] clr_set;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int model[$];

    always #2.5 clk = ~clk;

    set_history_table #(.ENTRIES(ENTRIES), .SET_W(SET_W)) u0 (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(acc_valid), .acc_set(acc_set), .acc_oph(acc_oph),
        .rm_valid(rm_valid), .rm_set(rm_set), .lk_set(lk_set),
        .lk_hit(lk_hit), .clr_valid(clr_valid), .clr_set(clr_set));

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit in_model(int k);
        foreach (model[i]) if (model[i] == k) return 1'b1;
        return 1'b0;
    endfunction

    function automatic void drop(int k);
        for (int i = 0; i < model.size(); i++) begin
            if (model[i] == k) begin
                model.delete(i);
                return;
            end
        end
    endfunction

    // One cycle: drive, check lookup same cycle, advance model, check pulse.
    task automatic step(bit av, int as, bit oph, bit rv, int rs, int ls, string req);
        bit exp_clr;
        @(negedge clk);
        acc_valid = av; acc_set = SET_W'(as); acc_oph = oph;
        rm_valid = rv;  rm_set = SET_W'(rs);  lk_set = SET_W'(ls);
        #1;
        chk(lk_hit == in_model(ls), {req, " lookup"}, lk_hit, in_model(ls));
        exp_clr = 1'b0;
        if (rv) drop(rs);
        if (av && !oph && !(rv && rs == as)) begin
            if (in_model(as)) begin
                drop(as);
                model.push_front(as);
            end else begin
                model.push_front(as);
                if (model.size() > ENTRIES) void'(model.pop_back());
                exp_clr = 1'b1;
            end
        end
        @(posedge clk);
        #1;
        chk(clr_valid == exp_clr, {req, " clr_valid"}, clr_valid, exp_clr);
        if (exp_clr) chk(clr_set == SET_W'(as), {req, " clr_set"}, clr_set, as);
    endtask

    task automatic idle_look(int ls, string req);
        step(1'b0, 0, 1'b0, 1'b0, 0, ls, req);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: empty after reset, no pulse.
        #1;
        chk(clr_valid == 1'b0, "R1 clr after reset", clr_valid, 0);
        for (int s = 0; s < 64; s += 7) idle_look(s, "R1");
        // R3 / R5 / R2: fill the table, each new index pulses.
        for (int s = 0; s < ENTRIES; s++) step(1'b1, s, 1'b0, 1'b0, 0, s, "R3 R5 fill");
        for (int s = 0; s < ENTRIES; s++) idle_look(s, "R2 R3 listed");
        // R6: re-reference 3, no pulse, then 0 is oldest.
        step(1'b1, 3, 1'b0, 1'b0, 0, 3, "R6 touch");
        step(1'b1, 20, 1'b0, 1'b0, 0, 0, "R7 insert when full");
        idle_look(0, "R7 oldest dropped");
        idle_look(3, "R7 touched kept");
        idle_look(1, "R7 others kept");
        // R4: out-of-position hit has no effect.
        step(1'b1, 30, 1'b1, 1'b0, 0, 30, "R4 oph");
        idle_look(30, "R4 oph not recorded");
        step(1'b1, 40, 1'b0, 1'b0, 0, 1, "R4 order kept");
        idle_look(1, "R4 order kept");
        // R8: removal and removal of an absent index.
        step(1'b0, 0, 1'b0, 1'b1, 5, 5, "R8 remove");
        idle_look(5, "R8 removed");
        step(1'b0, 0, 1'b0, 1'b1, 41, 6, "R8 absent remove");
        idle_look(6, "R8 absent remove");
        // R9: same index removed and accessed.
        step(1'b1, 6, 1'b0, 1'b1, 6, 6, "R9 remove wins");
        idle_look(6, "R9 remove wins");
        // R10: different indices in one cycle.
        step(1'b1, 50, 1'b0, 1'b1, 7, 2, "R10 both");
        for (int s = 0; s < 64; s++) idle_look(s, "R10 contents");
        // Mixed traffic over a small index range.
        for (int n = 0; n < 3000; n++) begin
            step($urandom_range(0, 9) < 8, $urandom_range(0, 13), $urandom_range(0, 4) == 0,
                 $urandom_range(0, 6) == 0, $urandom_range(0, 13), $urandom_range(0, 13),
                 "R3 R6 R7 R8 mixed");
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule